// File: doc/BRIEF.md
# DMA Peripheral Request Multiplexer

This block sits between a set of peripherals and a bank of DMA channel engines. The channels are grouped two by two. Each pair has one 4-bit selector that names the peripheral it serves. The even channel of a pair takes that peripheral's receive request, and the odd channel takes its transmit request. Going the other way, the acknowledges that the engines raise are sent back to the receive or transmit acknowledge line of the peripheral that was selected.

Two pairs may name the same peripheral. In that case the pair with the lower index owns that peripheral. Only the owner forwards requests and drives acknowledges, and a higher pair with a duplicate selection stays silent. Each channel has its own sense mode. In level mode the request passes straight through. In edge mode a rising request is latched and held until the engine acknowledges it, which suits sources that pulse their request.

Top module: `dreq_mux`

## Requirements
- R1: Pair p reads its selector from bits [4p+3:4p] of `sel_cfg`. Code 4'hF, and any code not below NUM_PERIPH, means no peripheral, and then neither channel of the pair ever requests.
- R2: Channel 2p forwards `periph_rx_req` of the selected peripheral and channel 2p+1 forwards `periph_tx_req`.
- R3: When several pairs hold the same live code, only the lowest-indexed of them forwards requests. The channels of every higher duplicate pair keep `ch_req` low.
- R4: `periph_rx_ack[k]` equals `ch_ack[2p]` and `periph_tx_ack[k]` equals `ch_ack[2p+1]`, where p is the pair that owns peripheral k. Acknowledges from pairs that do not own k have no effect on k, and a peripheral with no owner sees both acknowledges low.
- R5: With `sense_edge[c]`=0 (level), `ch_req[c]` follows the routed request in the same cycle, with no register in the path.
- R6: With `sense_edge[c]`=1 (edge), a routed request that is high at a clock edge after being low at the previous edge sets a pending flag. `ch_req[c]` is high from the next cycle and stays high, even if the request drops, until `ch_ack[c]` is sampled high. A new rising edge in the same cycle as the acknowledge wins over the acknowledge.
- R7: In edge mode, once an acknowledge has cleared the pending flag, a request that stays high raises nothing more. Only a fall followed by a new rise sets the flag again.
- R8: A synchronous active-low reset clears all pending flags and edge history, so every edge-mode `ch_req` is low while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_cfg | input | NUM_CH*2 | Peripheral selector, 4 bits per channel pair |
| sense_edge | input | NUM_CH | Sense mode per channel: 1 = edge, 0 = level |
| periph_rx_req | input | NUM_PERIPH | Receive request from each peripheral |
| periph_tx_req | input | NUM_PERIPH | Transmit request from each peripheral |
| ch_ack | input | NUM_CH | Acknowledge from each channel engine |
| ch_req | output | NUM_CH | Request to each channel engine |
| periph_rx_ack | output | NUM_PERIPH | Receive acknowledge to each peripheral |
| periph_tx_ack | output | NUM_PERIPH | Transmit acknowledge to each peripheral |

## Verification
The routing is driven from a table of selector maps, one case per entry:
- all pairs set to no peripheral;
- a single pair, with only its receive request active and then only its transmit request active, which separates the even path from the odd path;
- two pairs naming the same peripheral while a third names another;
- a duplicate pair following an unused pair, which shows that ownership follows the lowest live pair and not pair 0;
- the highest and lowest source codes on upper pairs.

For the duplicate cases, acknowledges are raised only on the non-owning pair, which shows that they are ignored. Directed sequences then run an edge-mode channel through capture, hold after the request drops, clearance by acknowledge, no re-trigger while the request is held high, and re-trigger after a new rise. Further sequences check that level mode is combinational and that reset clears a pending flag.

// File: rtl/dreq_mux_pkg.sv
package dreq_mux_pkg;
  localparam int unsigned SEL_W     = 4;
  localparam logic [SEL_W-1:0] CODE_NONE = 4'hF;

  // A selector code names a real source only if it is not the reserved
  // code and lies inside the populated source range.
  function automatic logic code_live(input logic [SEL_W-1:0] code,
                                     input int unsigned n_src);
    return (code != CODE_NONE) && (32'(code) < n_src);
  endfunction

  // Compare a selector code against a source index.
  function automatic logic code_is(input logic [SEL_W-1:0] code,
                                   input int unsigned idx);
    return 32'(code) == idx;
  endfunction
endpackage

// File: rtl/dreq_owner_arb.sv
module dreq_owner_arb
  import dreq_mux_pkg::*;
#(
  parameter int unsigned NUM_PAIR   = 4,
  parameter int unsigned NUM_PERIPH = 15
) (
  input  logic [NUM_PAIR*SEL_W-1:0] sel_cfg,
  output logic [NUM_PAIR-1:0]       pair_owns
);
  logic [SEL_W-1:0] sel_a [NUM_PAIR];

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_unpack
    assign sel_a[p] = sel_cfg[p*SEL_W +: SEL_W];
  end

  // A pair owns its source when the code is live and no lower pair
  // holds the same live code.
  always_comb begin
    for (int p = 0; p < NUM_PAIR; p++) begin
      pair_owns[p] = code_live(sel_a[p], NUM_PERIPH);
      for (int q = 0; q < NUM_PAIR; q++) begin
        if (q < p && code_live(sel_a[q], NUM_PERIPH) && (sel_a[q] == sel_a[p]))
          pair_owns[p] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/dreq_req_route.sv
module dreq_req_route
  import dreq_mux_pkg::*;
#(
  parameter int unsigned NUM_PAIR   = 4,
  parameter int unsigned NUM_PERIPH = 15
) (
  input  logic [NUM_PAIR*SEL_W-1:0] sel_cfg,
  input  logic [NUM_PAIR-1:0]       pair_owns,
  input  logic [NUM_PERIPH-1:0]     periph_rx_req,
  input  logic [NUM_PERIPH-1:0]     periph_tx_req,
  output logic [2*NUM_PAIR-1:0]     raw_req
);
  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
    logic [SEL_W-1:0] sel;
    logic             rx_hit;
    logic             tx_hit;
    assign sel = sel_cfg[p*SEL_W +: SEL_W];

    always_comb begin
      rx_hit = 1'b0;
      tx_hit = 1'b0;
      for (int k = 0; k < NUM_PERIPH; k++) begin
        if (code_is(sel, k)) begin
          rx_hit = periph_rx_req[k];
          tx_hit = periph_tx_req[k];
        end
      end
    end

    // Even channel takes the receive path, odd channel the transmit path.
    assign raw_req[2*p]   = pair_owns[p] & rx_hit;
    assign raw_req[2*p+1] = pair_owns[p] & tx_hit;
  end
endmodule

// File: rtl/dreq_ack_route.sv
module dreq_ack_route
  import dreq_mux_pkg::*;
#(
  parameter int unsigned NUM_PAIR   = 4,
  parameter int unsigned NUM_PERIPH = 15
) (
  input  logic [NUM_PAIR*SEL_W-1:0] sel_cfg,
  input  logic [NUM_PAIR-1:0]       pair_owns,
  input  logic [2*NUM_PAIR-1:0]     ch_ack,
  output logic [NUM_PERIPH-1:0]     periph_rx_ack,
  output logic [NUM_PERIPH-1:0]     periph_tx_ack
);
  always_comb begin
    periph_rx_ack = '0;
    periph_tx_ack = '0;
    for (int k = 0; k < NUM_PERIPH; k++) begin
      for (int p = 0; p < NUM_PAIR; p++) begin
        if (pair_owns[p] && code_is(sel_cfg[p*SEL_W +: SEL_W], k)) begin
          periph_rx_ack[k] = periph_rx_ack[k] | ch_ack[2*p];
          periph_tx_ack[k] = periph_tx_ack[k] | ch_ack[2*p+1];
        end
      end
    end
  end
endmodule

// File: rtl/dreq_sense_cell.sv
module dreq_sense_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic edge_mode,
  input  logic owned,
  input  logic ack,
  output logic req,
  output logic rise
);
  logic prev_q;
  logic pend_q;

  assign rise = raw & ~prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= raw;
      if (!edge_mode || !owned)
        pend_q <= 1'b0;
      else if (rise)
        pend_q <= 1'b1;
      else if (ack)
        pend_q <= 1'b0;
    end
  end

  assign req = edge_mode ? (pend_q & owned) : raw;
endmodule

// File: rtl/dreq_mux.sv
module dreq_mux
  import dreq_mux_pkg::*;
#(
  parameter int unsigned NUM_CH     = 8,
  parameter int unsigned NUM_PERIPH = 15
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [(NUM_CH/2)*SEL_W-1:0]   sel_cfg,
  input  logic [NUM_CH-1:0]             sense_edge,
  input  logic [NUM_PERIPH-1:0]         periph_rx_req,
  input  logic [NUM_PERIPH-1:0]         periph_tx_req,
  input  logic [NUM_CH-1:0]             ch_ack,
  output logic [NUM_CH-1:0]             ch_req,
  output logic [NUM_PERIPH-1:0]         periph_rx_ack,
  output logic [NUM_PERIPH-1:0]         periph_tx_ack
);
  localparam int unsigned NUM_PAIR = NUM_CH / 2;

  logic [NUM_PAIR-1:0] pair_owns;
  logic [NUM_CH-1:0]   raw_req;
  logic [NUM_CH-1:0]   req_rise;

  dreq_owner_arb #(.NUM_PAIR(NUM_PAIR), .NUM_PERIPH(NUM_PERIPH)) u_arb (
    .sel_cfg   (sel_cfg),
    .pair_owns (pair_owns)
  );

  dreq_req_route #(.NUM_PAIR(NUM_PAIR), .NUM_PERIPH(NUM_PERIPH)) u_req (
    .sel_cfg       (sel_cfg),
    .pair_owns     (pair_owns),
    .periph_rx_req (periph_rx_req),
    .periph_tx_req (periph_tx_req),
    .raw_req       (raw_req)
  );

  dreq_ack_route #(.NUM_PAIR(NUM_PAIR), .NUM_PERIPH(NUM_PERIPH)) u_ack (
    .sel_cfg       (sel_cfg),
    .pair_owns     (pair_owns),
    .ch_ack        (ch_ack),
    .periph_rx_ack (periph_rx_ack),
    .periph_tx_ack (periph_tx_ack)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cell
    dreq_sense_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .raw       (raw_req[c]),
      .edge_mode (sense_edge[c]),
      .owned     (pair_owns[c/2]),
      .ack       (ch_ack[c]),
      .req       (ch_req[c]),
      .rise      (req_rise[c])
    );
  end
endmodule

// File: rtl/dreq_mux_chk.sv
module dreq_mux_chk
  import dreq_mux_pkg::*;
#(
  parameter int unsigned NUM_CH     = 8,
  parameter int unsigned NUM_PERIPH = 15
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [(NUM_CH/2)*SEL_W-1:0] sel_cfg,
  input logic [NUM_CH-1:0]           sense_edge,
  input logic [NUM_CH-1:0]           ch_ack,
  input logic [NUM_CH-1:0]           ch_req,
  input logic [NUM_PERIPH-1:0]       periph_rx_ack,
  input logic [NUM_PERIPH-1:0]       periph_tx_ack,
  input logic [NUM_CH/2-1:0]         pair_owns,
  input logic [NUM_CH-1:0]           raw_req
);
  localparam int unsigned NUM_PAIR = NUM_CH / 2;

  logic [NUM_CH-1:0] seen_q;
  always_ff @(posedge clk) begin
    if (!rst_n) seen_q <= '0;
    else        seen_q <= raw_req;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    // R1 and R3: a pair without ownership never requests
    p_unowned_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !pair_owns[c/2] |-> !ch_req[c]);

    // R5: level mode passes the routed request through
    p_level_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !sense_edge[c] |-> (ch_req[c] == raw_req[c]));

    // R6: a rising edge is captured for the next cycle
    p_edge_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_edge[c] && raw_req[c] && !seen_q[c])
      |=> (ch_req[c] || !sense_edge[c] || !pair_owns[c/2]));

    // R6: a pending request holds until acknowledged
    p_edge_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_edge[c] && ch_req[c] && !ch_ack[c])
      |=> (ch_req[c] || !sense_edge[c] || !pair_owns[c/2]));

    // R7: an acknowledge without a new rise clears the request
    p_edge_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_edge[c] && ch_ack[c] && !(raw_req[c] && !seen_q[c]))
      |=> (!ch_req[c] || !sense_edge[c]));
  end

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
    for (genvar k = 0; k < NUM_PERIPH; k++) begin : g_src
      // R4: the owner's acknowledges reach the selected source
      p_ack_route_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_owns[p] && code_is(sel_cfg[p*SEL_W +: SEL_W], k))
        |-> (periph_rx_ack[k] == ch_ack[2*p] && periph_tx_ack[k] == ch_ack[2*p+1]));
    end
  end
endmodule

bind dreq_mux dreq_mux_chk #(.NUM_CH(NUM_CH), .NUM_PERIPH(NUM_PERIPH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sel_cfg       (sel_cfg),
  .sense_edge    (sense_edge),
  .ch_ack        (ch_ack),
  .ch_req        (ch_req),
  .periph_rx_ack (periph_rx_ack),
  .periph_tx_ack (periph_tx_ack),
  .pair_owns     (pair_owns),
  .raw_req       (raw_req)
);

// File: tb/dreq_mux_tb.sv
module dreq_mux_tb;
  localparam int NCH = 8;
  localparam int NP  = 15;
  localparam int NV  = 7;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [31:0]   sel_cfg;
  logic [NCH-1:0] sense_edge;
  logic [NP-1:0] rx_req, tx_req, rx_ack, tx_ack;
  logic [NCH-1:0] ch_ack, ch_req;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dreq_mux #(.NUM_CH(NCH), .NUM_PERIPH(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_cfg(sel_cfg), .sense_edge(sense_edge),
    .periph_rx_req(rx_req), .periph_tx_req(tx_req), .ch_ack(ch_ack),
    .ch_req(ch_req), .periph_rx_ack(rx_ack), .periph_tx_ack(tx_ack)
  );

  // sel(32) rx_req(15) tx_req(15) ch_ack(8) | exp ch_req(8) exp rx_ack(15) exp tx_ack(15)
  localparam logic [107:0] TBL [0:NV-1] = '{
    {32'hFFFF_FFFF, 15'h7FFF, 15'h7FFF, 8'hFF, 8'h00, 15'h0000, 15'h0000},
    {32'hFFFF_FFF3, 15'h0008, 15'h0000, 8'h00, 8'h01, 15'h0000, 15'h0000},
    {32'hFFFF_FFF3, 15'h0000, 15'h0008, 8'h02, 8'h02, 15'h0000, 15'h0008},
    {32'hFFFF_F255, 15'h0024, 15'h0024, 8'hFF, 8'h33, 15'h0024, 15'h0024},
    {32'hFFFF_F255, 15'h0000, 15'h0000, 8'h0C, 8'h00, 15'h0000, 15'h0000},
    {32'hFFFF_0E7F, 15'h0001, 15'h4000, 8'h40, 8'h60, 15'h0001, 15'h0000},
    {32'hFFFF_F99F, 15'h0200, 15'h0200, 8'h30, 8'h0C, 15'h0000, 15'h0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sel_cfg = 32'hFFFF_FFFF; sense_edge = '0;
    rx_req = '0; tx_req = '0; ch_ack = '0;
    @(negedge clk); tick();
    chk("R8 reset ch_req", 32'(ch_req), 32'h0);
    chk("R1 reset acks", {2'b0, rx_ack, tx_ack}, 32'h0);
    rst_n = 1'b1;
    tick();

    // Table of routing vectors, level sense everywhere (R1 R2 R3 R4 R5)
    for (int i = 0; i < NV; i++) begin
      {sel_cfg, rx_req, tx_req, ch_ack} = TBL[i][107:38];
      #1;
      chk($sformatf("R2/R3 vec%0d ch_req", i), 32'(ch_req), 32'(TBL[i][37:30]));
      chk($sformatf("R4 vec%0d rx_ack", i), 32'(rx_ack), 32'(TBL[i][29:15]));
      chk($sformatf("R4 vec%0d tx_ack", i), 32'(tx_ack), 32'(TBL[i][14:0]));
      tick();
    end

    // R5: level path is combinational
    sel_cfg = 32'hFFFF_FFF3; rx_req = '0; tx_req = '0; ch_ack = '0;
    tick();
    rx_req[3] = 1'b1; #1;
    chk("R5 level same cycle high", 32'(ch_req[0]), 32'd1);
    rx_req[3] = 1'b0; #1;
    chk("R5 level same cycle low", 32'(ch_req[0]), 32'd0);

    // R6: edge capture and hold on channel 1
    sense_edge = 8'h02;
    tick();
    chk("R6 idle", 32'(ch_req[1]), 32'd0);
    tx_req[3] = 1'b1; #1;
    chk("R6 not combinational", 32'(ch_req[1]), 32'd0);
    tick();
    chk("R6 captured", 32'(ch_req[1]), 32'd1);
    tx_req[3] = 1'b0;
    tick(); tick();
    chk("R6 held after drop", 32'(ch_req[1]), 32'd1);
    ch_ack[1] = 1'b1; #1;
    chk("R4 tx ack routed", 32'(tx_ack), 32'h0008);
    tick();
    ch_ack[1] = 1'b0;
    chk("R6 cleared by ack", 32'(ch_req[1]), 32'd0);

    // R6: rise and ack in the same cycle, rise wins
    tx_req[3] = 1'b1; ch_ack[1] = 1'b1;
    tick();
    ch_ack[1] = 1'b0;
    chk("R6 rise beats ack", 32'(ch_req[1]), 32'd1);

    // R7: held-high request does not re-trigger after ack
    ch_ack[1] = 1'b1;
    tick();
    ch_ack[1] = 1'b0;
    tick(); tick();
    chk("R7 no retrigger while high", 32'(ch_req[1]), 32'd0);
    tx_req[3] = 1'b0;
    tick();
    tx_req[3] = 1'b1;
    tick();
    chk("R7 retrigger after new rise", 32'(ch_req[1]), 32'd1);

    // R8: reset clears a pending edge request
    tx_req[3] = 1'b0;
    rst_n = 1'b0;
    tick();
    chk("R8 reset clears pending", 32'(ch_req[1]), 32'd0);
    rst_n = 1'b1;
    tick();
    chk("R8 stays clear after reset", 32'(ch_req[1]), 32'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule